// File: doc/BRIEF.md
# Sync Trigger and Clock Router

This block sits inside one I/O module. It connects that module to four shared sync lines and to two external sync inputs. The shared lines are pulled up passively, and any participant may pull them low. Each shared line has a fixed role:

- line 0 carries an incoming trigger.
- line 1 carries an incoming clock.
- line 2 is where a module publishes its own trigger.
- line 3 is where a module publishes its own clock.

The router picks one trigger source and qualifies it into a `run` level. Four qualification modes are available: a single start edge, a start/stop pair of edges, and two gate modes. Each time `run` rises, the router emits a one-cycle start pulse. Every started module uses that pulse to clear its local timestamp counter, so all modules stay aligned.

The router also picks one clock source for the module. Optionally, it pulls line 2 or line 3 low through open-drain enables so that the module's own trigger or clock reaches the other modules. A separate single-bit sync output can carry one of three things: a resynchronised copy of external input 0, the internal clock, or a signal supplied by the module.

All asynchronous inputs pass through a synchroniser chain before any decision is made. The external inputs and the sync lines count as asynchronous. The software start strobe and the internal and software clocks are already in the block's clock domain and bypass the synchroniser.

Top module: `sync_route`

## Requirements
- R1: External inputs and sync lines pass through a two-flop synchroniser.
  - A change on one of these inputs reaches `run`, `clk_out` and `sync_out` at the third rising clock edge after it is applied.
  - A change on `sw_start`, `int_clk`, `sw_clk` or `mod_sig` reaches them at the first edge.
- R2: `cfg_trig_src` selects the trigger source: 0 = `sw_start`, 1 = `ext_in[0]`, 2 = `sync_in[0]`, 3 = `sync_in[2]`.
- R3: With `cfg_trig_mode` = 0 (single edge), the first qualifying edge sets `run`, and `run` then holds until `arm` drops.
  - `cfg_trig_fall` = 0 selects rising edges; 1 selects falling edges.
- R4: With `cfg_trig_mode` = 1 (start/stop), every qualifying edge toggles `run`. Edges of the other polarity have no effect.
- R5: With `cfg_trig_mode` = 2, `run` follows the synchronised source level. With `cfg_trig_mode` = 3, `run` follows the inverse of that level.
- R6: While `arm` is low, `run` is cleared at the next edge and trigger activity is ignored.
- R7: `start_pulse` is high for exactly the one cycle in which `run` has just risen.
- R8: `cfg_clk_src` selects the clock, registered once: 0 = `sw_clk`, 1 = `int_clk`, 2 = `ext_in[1]`, 3 = a sync line.
  - For code 3, `cfg_clk_line` = 0 selects `sync_in[1]` and `cfg_clk_line` = 1 selects `sync_in[3]`.
- R9: The router never pulls lines 0 or 1.
  - `sync_oe[2]` is high only when `cfg_drive_trig` is set and `run` is low.
  - `sync_oe[3]` is high only when `cfg_drive_clk` is set and `clk_out` is low.
- R10: `cfg_out_mode` selects the registered `sync_out`: 0 = synchronised `ext_in[0]`, 1 = `int_clk`, 2 = `mod_sig`, 3 = held low.
- R11: No edge is recognised in the cycle in which `cfg_trig_src` changes. This prevents the level difference between the old and new source from starting `run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_start | input | 1 | Software start strobe (clock domain) |
| sw_clk | input | 1 | Software-paced clock level |
| int_clk | input | 1 | Internal timebase level |
| mod_sig | input | 1 | Module signal for the sync output |
| ext_in | input | 2 | External sync inputs: bit 0 trigger, bit 1 clock (asynchronous) |
| sync_in | input | 4 | Levels sensed on the shared sync lines (asynchronous) |
| arm | input | 1 | Enables trigger qualification |
| cfg_trig_src | input | 2 | Trigger source code |
| cfg_trig_mode | input | 2 | Qualification mode code |
| cfg_trig_fall | input | 1 | Edge polarity, 1 = falling |
| cfg_clk_src | input | 2 | Clock source code |
| cfg_clk_line | input | 1 | Sync line choice for clock code 3 |
| cfg_drive_trig | input | 1 | Publish `run` on line 2 |
| cfg_drive_clk | input | 1 | Publish `clk_out` on line 3 |
| cfg_out_mode | input | 2 | Sync output source code |
| run | output | 1 | Qualified run level |
| start_pulse | output | 1 | One-cycle timestamp reset at each start |
| clk_out | output | 1 | Selected clock level |
| sync_oe | output | 4 | Open-drain pull-low enables, one per line |
| sync_out | output | 1 | Sync output level |

## Verification
The checker watches several relations on every cycle:

- the start pulse is single and coincides with a fresh rise of `run`;
- `run` is cleared one cycle after `arm` is low, and a single-edge start holds while armed;
- the open-drain enables never touch lines 0 and 1, and pull lines 2 and 3 only under the stated conditions;
- the sync output stays low in its forced-low mode.

The bench scenarios show the behaviours that depend on input history and latency:

- the three-edge synchroniser delay;
- edge polarity and toggling in start/stop mode;
- gate following;
- the mapping of every source code;
- suppression of a false edge when the trigger source is switched.

// File: rtl/sync_route_pkg.sv
package sync_route_pkg;

    typedef enum logic [1:0] {
        TSRC_SW    = 2'd0,
        TSRC_EXT0  = 2'd1,
        TSRC_LINE0 = 2'd2,
        TSRC_LINE2 = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        TM_EDGE    = 2'd0,
        TM_TOGGLE  = 2'd1,
        TM_GATE_HI = 2'd2,
        TM_GATE_LO = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        CSRC_SW   = 2'd0,
        CSRC_INT  = 2'd1,
        CSRC_EXT1 = 2'd2,
        CSRC_LINE = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        OM_EXT_COPY = 2'd0,
        OM_INT_CLK  = 2'd1,
        OM_MODULE   = 2'd2,
        OM_LOW      = 2'd3
    } out_mode_e;

    // fixed roles of the shared lines and external inputs
    localparam int LINE_TRIG_IN    = 0;
    localparam int LINE_CLK_IN     = 1;
    localparam int LINE_TRIG_SHARE = 2;
    localparam int LINE_CLK_SHARE  = 3;
    localparam int EXT_TRIG        = 0;
    localparam int EXT_CLK         = 1;

    typedef struct packed {
        logic sw;
        logic ext0;
        logic line0;
        logic line2;
    } trig_view_t;

    typedef struct packed {
        logic sw;
        logic intc;
        logic ext1;
        logic line1;
        logic line3;
    } clk_view_t;

    function automatic logic pick_trig(trig_src_e s, trig_view_t v);
        case (s)
            TSRC_SW:    return v.sw;
            TSRC_EXT0:  return v.ext0;
            TSRC_LINE0: return v.line0;
            default:    return v.line2;
        endcase
    endfunction

    function automatic logic pick_clk(clk_src_e s, logic line_sel, clk_view_t v);
        case (s)
            CSRC_SW:   return v.sw;
            CSRC_INT:  return v.intc;
            CSRC_EXT1: return v.ext1;
            default:   return line_sel ? v.line3 : v.line1;
        endcase
    endfunction

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sr_trig_qual.sv
module sr_trig_qual
    import sync_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  trig_mode_e mode,
    input  logic       fall,
    input  trig_src_e  src_sel,
    input  logic       src_now,
    output logic       run,
    output logic       start_pulse
);
    logic      prev_q;
    trig_src_e src_q;
    logic      run_q;
    logic      pulse_q;
    logic      same_src;
    logic      edge_ok;
    logic      run_next;
    logic      run_d;

    // history is only meaningful while the source has not just changed
    assign same_src = (src_sel == src_q);
    assign edge_ok  = same_src & (fall ? (prev_q & ~src_now) : (src_now & ~prev_q));

    always_comb begin
        case (mode)
            TM_EDGE:    run_next = run_q | edge_ok;
            TM_TOGGLE:  run_next = run_q ^ edge_ok;
            TM_GATE_HI: run_next = src_now;
            default:    run_next = ~src_now;
        endcase
        run_d = arm & run_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            src_q   <= TSRC_SW;
            run_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= src_now;
            src_q   <= src_sel;
            run_q   <= run_d;
            pulse_q <= run_d & ~run_q;
        end
    end

    assign run         = run_q;
    assign start_pulse = pulse_q;
endmodule

// File: rtl/sr_clk_sel.sv
module sr_clk_sel
    import sync_route_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  clk_src_e  src,
    input  logic      line_sel,
    input  clk_view_t view,
    output logic      clk_out
);
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= pick_clk(src, line_sel, view);
    end

    assign clk_out = sel_q;
endmodule

// File: rtl/sync_route.sv
module sync_route
    import sync_route_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int N_EXT       = 2,
    parameter int N_LINES     = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_start,
    input  logic               sw_clk,
    input  logic               int_clk,
    input  logic               mod_sig,
    input  logic [N_EXT-1:0]   ext_in,
    input  logic [N_LINES-1:0] sync_in,
    input  logic               arm,
    input  logic [1:0]         cfg_trig_src,
    input  logic [1:0]         cfg_trig_mode,
    input  logic               cfg_trig_fall,
    input  logic [1:0]         cfg_clk_src,
    input  logic               cfg_clk_line,
    input  logic               cfg_drive_trig,
    input  logic               cfg_drive_clk,
    input  logic [1:0]         cfg_out_mode,
    output logic               run,
    output logic               start_pulse,
    output logic               clk_out,
    output logic [N_LINES-1:0] sync_oe,
    output logic               sync_out
);
    // idle level of a passively pulled-up line is high
    localparam logic [N_LINES-1:0] LINE_IDLE = {N_LINES{1'b1}};
    localparam logic [N_EXT-1:0]   EXT_IDLE  = '0;

    logic [N_EXT-1:0]   ext_s;
    logic [N_LINES-1:0] line_s;
    trig_view_t         tview;
    clk_view_t          cview;
    logic               trig_lvl;
    logic               out_q;

    sr_sync #(.W(N_EXT), .STAGES(SYNC_STAGES), .RST_VAL(EXT_IDLE)) u_ext_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_in),
        .q   (ext_s)
    );

    sr_sync #(.W(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)) u_line_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_in),
        .q   (line_s)
    );

    assign tview = '{sw: sw_start, ext0: ext_s[EXT_TRIG],
                     line0: line_s[LINE_TRIG_IN], line2: line_s[LINE_TRIG_SHARE]};
    assign cview = '{sw: sw_clk, intc: int_clk, ext1: ext_s[EXT_CLK],
                     line1: line_s[LINE_CLK_IN], line3: line_s[LINE_CLK_SHARE]};

    assign trig_lvl = pick_trig(trig_src_e'(cfg_trig_src), tview);

    sr_trig_qual u_qual (
        .clk         (clk),
        .rst         (rst),
        .arm         (arm),
        .mode        (trig_mode_e'(cfg_trig_mode)),
        .fall        (cfg_trig_fall),
        .src_sel     (trig_src_e'(cfg_trig_src)),
        .src_now     (trig_lvl),
        .run         (run),
        .start_pulse (start_pulse)
    );

    sr_clk_sel u_clk (
        .clk      (clk),
        .rst      (rst),
        .src      (clk_src_e'(cfg_clk_src)),
        .line_sel (cfg_clk_line),
        .view     (cview),
        .clk_out  (clk_out)
    );

    // open-drain pull-low: only the publishing lines may ever be driven
    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_oe
            if (g == LINE_TRIG_SHARE) begin : g_trig
                assign sync_oe[g] = cfg_drive_trig & ~run;
            end else if (g == LINE_CLK_SHARE) begin : g_clk
                assign sync_oe[g] = cfg_drive_clk & ~clk_out;
            end else begin : g_none
                assign sync_oe[g] = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
        end else begin
            case (out_mode_e'(cfg_out_mode))
                OM_EXT_COPY: out_q <= ext_s[EXT_TRIG];
                OM_INT_CLK:  out_q <= int_clk;
                OM_MODULE:   out_q <= mod_sig;
                default:     out_q <= 1'b0;
            endcase
        end
    end

    assign sync_out = out_q;
endmodule

// File: rtl/sync_route_chk.sv
module sync_route_chk (
    input logic       clk,
    input logic       rst,
    input logic       arm,
    input logic [1:0] cfg_trig_mode,
    input logic [1:0] cfg_out_mode,
    input logic       cfg_drive_trig,
    input logic       cfg_drive_clk,
    input logic       run,
    input logic       start_pulse,
    input logic       clk_out,
    input logic [3:0] sync_oe,
    input logic       sync_out
);
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    p_pulse_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (run && !$past(run)));

    p_disarm_clears_r6: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !run);

    p_edge_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (run && arm && cfg_trig_mode == 2'd0) |=> run);

    p_input_lines_free_r9: assert property (@(posedge clk) disable iff (rst)
        sync_oe[1:0] == 2'b00);

    p_trig_pull_r9: assert property (@(posedge clk) disable iff (rst)
        sync_oe[2] |-> (cfg_drive_trig && !run));

    p_clk_pull_r9: assert property (@(posedge clk) disable iff (rst)
        sync_oe[3] |-> (cfg_drive_clk && !clk_out));

    p_out_low_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_out_mode == 2'd3) |=> !sync_out);
endmodule

bind sync_route sync_route_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .arm            (arm),
    .cfg_trig_mode  (cfg_trig_mode),
    .cfg_out_mode   (cfg_out_mode),
    .cfg_drive_trig (cfg_drive_trig),
    .cfg_drive_clk  (cfg_drive_clk),
    .run            (run),
    .start_pulse    (start_pulse),
    .clk_out        (clk_out),
    .sync_oe        (sync_oe),
    .sync_out       (sync_out)
);

// File: tb/sim_sync_route.sv
module sim_sync_route;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_start = 0, sw_clk = 0, int_clk = 0, mod_sig = 0;
    logic [1:0] ext_in = 2'b00;
    logic [3:0] sync_in = 4'hF;
    logic       arm = 0;
    logic [1:0] cfg_trig_src = 0, cfg_trig_mode = 0, cfg_clk_src = 0, cfg_out_mode = 0;
    logic       cfg_trig_fall = 0, cfg_clk_line = 0, cfg_drive_trig = 0, cfg_drive_clk = 0;
    logic       run, start_pulse, clk_out, sync_out;
    logic [3:0] sync_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sync_route u0 (
        .clk(clk), .rst(rst), .sw_start(sw_start), .sw_clk(sw_clk), .int_clk(int_clk),
        .mod_sig(mod_sig), .ext_in(ext_in), .sync_in(sync_in), .arm(arm),
        .cfg_trig_src(cfg_trig_src), .cfg_trig_mode(cfg_trig_mode),
        .cfg_trig_fall(cfg_trig_fall), .cfg_clk_src(cfg_clk_src),
        .cfg_clk_line(cfg_clk_line), .cfg_drive_trig(cfg_drive_trig),
        .cfg_drive_clk(cfg_drive_clk), .cfg_out_mode(cfg_out_mode),
        .run(run), .start_pulse(start_pulse), .clk_out(clk_out),
        .sync_oe(sync_oe), .sync_out(sync_out)
    );

    // clock-select vectors: src[8:7] line[6] sw[5] int[4] ext1[3] s1[2] s3[1] expect[0]
    localparam int NV = 9;
    localparam logic [8:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("reset run", run, 0);
        chk("reset start_pulse", start_pulse, 0);
        chk("reset sync_oe", sync_oe, 0);
        chk("reset clk_out", clk_out, 0);

        // R2 R3 R7: software source, single rising edge
        arm = 1; tick(1);
        sw_start = 1; tick(1);
        chk("R3 run after sw edge", run, 1);
        chk("R7 start pulse high", start_pulse, 1);
        sw_start = 0; tick(1);
        chk("R7 start pulse single", start_pulse, 0);
        chk("R3 run held", run, 1);
        sw_start = 1; tick(1); sw_start = 0;
        chk("R7 no pulse on re-edge", start_pulse, 0);
        arm = 0; tick(1);
        chk("R6 disarm clears", run, 0);
        sw_start = 1; tick(1); sw_start = 0;
        chk("R6 edge ignored when disarmed", run, 0);

        // R1 R4: external 0, start/stop on falling edges
        cfg_trig_src = 1; cfg_trig_mode = 1; cfg_trig_fall = 1;
        ext_in[0] = 1; tick(4);
        arm = 1; tick(2);
        chk("R4 no edge yet", run, 0);
        ext_in[0] = 0; tick(2);
        chk("R1 not before third edge", run, 0);
        tick(1);
        chk("R1 run at third edge", run, 1);
        chk("R7 pulse on toggle start", start_pulse, 1);
        ext_in[0] = 1; tick(4);
        chk("R4 rising ignored in fall mode", run, 1);
        ext_in[0] = 0; tick(3);
        chk("R4 second edge stops", run, 0);

        // R5: gate modes on sync line 0
        cfg_trig_src = 2; cfg_trig_mode = 2; tick(4);
        chk("R5 gate high follows line", run, 1);
        sync_in[0] = 0; tick(2);
        chk("R5 gate high before sync delay", run, 1);
        tick(1);
        chk("R5 gate high drops", run, 0);
        cfg_trig_mode = 3; tick(1);
        chk("R5 gate low runs", run, 1);
        arm = 0; tick(1);
        sync_in[0] = 1;

        // R11: switching to a high line must not start
        cfg_trig_src = 0; cfg_trig_mode = 0; cfg_trig_fall = 0; tick(2);
        arm = 1; tick(1);
        cfg_trig_src = 3; tick(3);
        chk("R11 no false edge on source change", run, 0);
        sync_in[2] = 0; tick(4);
        sync_in[2] = 1; tick(2);
        chk("R2 line2 edge not yet", run, 0);
        tick(1);
        chk("R2 line2 edge starts", run, 1);

        // R9: trigger publish on line 2
        cfg_drive_trig = 1; tick(1);
        chk("R9 no pull while running", sync_oe[2], 0);
        arm = 0; tick(1);
        chk("R9 pull when stopped", sync_oe[2], 1);
        cfg_drive_trig = 0; tick(1);
        chk("R9 released when not publishing", sync_oe[2], 0);

        // R8 R9: clock-select vector walk with clock publishing on
        cfg_drive_clk = 1;
        for (int i = 0; i < NV; i++) begin
            cfg_clk_src  = VEC[i][8:7];
            cfg_clk_line = VEC[i][6];
            sw_clk       = VEC[i][5];
            int_clk      = VEC[i][4];
            ext_in[1]    = VEC[i][3];
            sync_in      = {VEC[i][1], 1'b1, VEC[i][2], 1'b1};
            tick(4);
            chk($sformatf("R8 clock vector %0d", i), clk_out, VEC[i][0]);
            chk($sformatf("R9 clock pull vector %0d", i), sync_oe, {~VEC[i][0], 3'b000});
        end
        cfg_drive_clk = 0;

        // R1: external clock latency
        cfg_clk_src = 2; ext_in[1] = 0; tick(4);
        ext_in[1] = 1; tick(2);
        chk("R1 ext clock not yet", clk_out, 0);
        tick(1);
        chk("R1 ext clock at third edge", clk_out, 1);
        cfg_clk_src = 1; int_clk = 0; tick(1);
        chk("R1 internal clock at first edge", clk_out, 0);

        // R10: sync output modes
        cfg_out_mode = 1; int_clk = 1; tick(1);
        chk("R10 internal clock out", sync_out, 1);
        cfg_out_mode = 2; mod_sig = 0; tick(1);
        chk("R10 module signal low", sync_out, 0);
        mod_sig = 1; tick(1);
        chk("R10 module signal high", sync_out, 1);
        cfg_out_mode = 3; tick(1);
        chk("R10 forced low", sync_out, 0);
        cfg_out_mode = 0; ext_in[0] = 1; tick(2);
        chk("R10 ext copy not yet", sync_out, 0);
        tick(1);
        chk("R10 ext copy", sync_out, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule